// File: doc/BRIEF.md
# Timer Event Flags with Shared Interrupt

This block is a byte-addressed 16-bit free-running timer for a small 8-bit processor bus. Next to the counter sit two output-compare channels, one input-capture channel and a status byte that records four events: capture, compare 0, compare 1 and counter wrap. Each event flag can be routed to one shared interrupt request through its own enable bit in the control byte. Any masking of that request is done by the processor core, not by this block.

Software clears a flag in two steps. First it reads the status byte while that flag is set, which arms the flag. Then it touches the low byte of the data register that belongs to the flag. The counter uses a high-byte-first read, and the low byte is held at the moment the high byte is read, so a two-byte read gives a consistent value. The register window sits at a 16-byte-aligned base address, which is $10 by default.

Top module: `evtimer_top`

## Requirements
- R1: After reset the control byte reads 0x00, all four flags are clear and `irq` is low. The status byte at offset 1 reads as {capture flag bit7, compare-0 flag bit6, compare-1 flag bit5, wrap flag bit4, synchronised pin level bit3, 3'b000}. Bits 2..0 always read 0.
- R2: The counter advances by one on every clock. A read of offset 8 returns the high byte and holds the low byte of the same count. The next read of offset 9 returns that held byte.
- R3: A compare flag (bit6 for channel 0 at offsets 4/5, bit5 for channel 1 at offsets 6/7, high/low) sets on the clock edge that follows a cycle in which the counter equals the compare value.
- R4: The wrap flag (bit4) sets on the edge where the counter goes from 16'hFFFF to 16'h0000.
- R5: The capture edge is chosen by control bit1: 1 selects rising, 0 (the reset value) selects falling. The selected edge of the synchronised pin sets bit7 and copies the count of the detecting cycle into offsets 2/3. The other edge has no effect.
- R6: A status read that sees a flag set arms that flag. A later read or write of offset 3, 5 or 7 (capture, compare 0, compare 1), or a read of offset 9 (wrap), then clears it.
- R7: A low-byte access to a flag that is not armed leaves the flag set. This includes a flag that was clear during the last status read and has set since then. Accessing a high byte never clears a flag.
- R8: When an event and a valid clear fall in the same cycle, the flag stays set.
- R9: Control bits 7..4 enable the capture, compare-0, compare-1 and wrap flags. `irq` is a register holding the OR of (flag AND enable). It falls one clock after the last enabled flag clears.
- R10: Status bit3 shows the capture pin level one clock after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| cap_pin | input | 1 | Input-capture pin |
| irq | output | 1 | Shared timer interrupt request |

## Verification
The hardest case to reach is a capture event landing in the very cycle of an armed low-byte access, where the set must win over the clear. The bench gets there by counting synchroniser stages. It toggles the pin at the same falling clock edge that launches the arming status read. The detected edge then appears exactly one cycle later, which is the cycle of the low-byte access at offset 3. The wrap flag and the compare flags are timed the same way: the bench takes a coherent counter reading and predicts the exact cycle in which the flag first becomes visible.

// File: rtl/evtimer_pkg.sv
// Shared constants and register offsets for the event timer.
// Assumes an 8-bit data bus and a 16-bit counter split into two bytes.
package evtimer_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int NFLAG  = 4;

    // Flag vector index; status/control bit = index + 4
    localparam int FL_WRAP = 0;
    localparam int FL_OC1  = 1;
    localparam int FL_OC0  = 2;
    localparam int FL_CAP  = 3;

    typedef enum logic [3:0] {
        OFS_CTRL = 4'h0,
        OFS_STAT = 4'h1,
        OFS_CAPH = 4'h2,
        OFS_CAPL = 4'h3,
        OFS_OC0H = 4'h4,
        OFS_OC0L = 4'h5,
        OFS_OC1H = 4'h6,
        OFS_OC1L = 4'h7,
        OFS_CNTH = 4'h8,
        OFS_CNTL = 4'h9
    } reg_ofs_e;
endpackage

// File: rtl/evtimer_counter.sv
// Free-running counter with a wrap pulse and a coherent low-byte hold.
// Assumes hi_rd/lo_rd are single-cycle read strobes for the two count bytes.
module evtimer_counter import evtimer_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_rd,
    input  logic              lo_rd,
    output logic [CNT_W-1:0]  cnt,
    output logic              wrap,
    output logic [BYTE_W-1:0] lo_view
);
    logic [BYTE_W-1:0] lo_hold;
    logic              hold_vld;

    // Counter wraps to zero on the edge after all ones
    assign wrap = &cnt;

    // Advance the count every clock
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Hold the low byte when the high byte is read; release on low read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_hold  <= '0;
            hold_vld <= 1'b0;
        end else if (hi_rd) begin
            lo_hold  <= cnt[BYTE_W-1:0];
            hold_vld <= 1'b1;
        end else if (lo_rd) begin
            hold_vld <= 1'b0;
        end
    end

    // Present held byte if a high-byte read preceded
    assign lo_view = hold_vld ? lo_hold : cnt[BYTE_W-1:0];
endmodule

// File: rtl/evtimer_capture.sv
// Pin synchroniser, edge selector and capture latch.
// Assumes cap_pin is asynchronous; one sync stage plus one history stage.
module evtimer_capture import evtimer_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic             rise_sel,
    input  logic [CNT_W-1:0] cnt,
    output logic             pin_lvl,
    output logic             cap_evt,
    output logic [CNT_W-1:0] cap_val
);
    logic pin_d;

    // Sample the pin and keep one cycle of history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_lvl <= 1'b0;
            pin_d   <= 1'b0;
        end else begin
            pin_lvl <= cap_pin;
            pin_d   <= pin_lvl;
        end
    end

    // Detect the selected edge on the synchronised level
    assign cap_evt = rise_sel ? (pin_lvl & ~pin_d) : (~pin_lvl & pin_d);

    // Latch the count of the detecting cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_val <= '0;
        else if (cap_evt) cap_val <= cnt;
    end
endmodule

// File: rtl/evtimer_flag.sv
// One event flag with its private arm bit for the two-step clear.
// Assumes stat_rd and clr_acc are never high in the same cycle.
module evtimer_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic stat_rd,
    input  logic clr_acc,
    output logic flag
);
    logic armed;

    // Event sets the flag; an armed clear access drops it; set wins
    always_ff @(posedge clk) begin
        if (!rst_n)                flag <= 1'b0;
        else if (set_evt)          flag <= 1'b1;
        else if (clr_acc && armed) flag <= 1'b0;
    end

    // Arm on a status read that sees the flag; any clear access disarms
    always_ff @(posedge clk) begin
        if (!rst_n)                armed <= 1'b0;
        else if (clr_acc)          armed <= 1'b0;
        else if (stat_rd && flag)  armed <= 1'b1;
    end
endmodule

// File: rtl/evtimer_top.sv
// Event timer: register decode, compare channels, flags and interrupt.
// Assumes BASE is aligned to 16 bytes and one access per strobe cycle.
module evtimer_top import evtimer_pkg::*; #(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              cap_pin,
    output logic              irq
);
    logic              hit, rd, wr, acc, stat_rd;
    reg_ofs_e          ofs;
    logic [NFLAG-1:0]  en, flags, set_evt, clr_acc;
    logic              rise_sel;
    logic [CNT_W-1:0]  oc0, oc1, cnt, cap_val;
    logic              wrap, pin_lvl, cap_evt;
    logic [BYTE_W-1:0] lo_view;

    // Address decode
    assign hit     = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
    assign ofs     = reg_ofs_e'(addr[3:0]);
    assign rd      = hit && rd_en;
    assign wr      = hit && wr_en;
    assign acc     = rd || wr;
    assign stat_rd = rd && (ofs == OFS_STAT);

    evtimer_counter u_cnt (
        .clk(clk), .rst_n(rst_n),
        .hi_rd(rd && (ofs == OFS_CNTH)), .lo_rd(rd && (ofs == OFS_CNTL)),
        .cnt(cnt), .wrap(wrap), .lo_view(lo_view)
    );

    evtimer_capture u_cap (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .rise_sel(rise_sel),
        .cnt(cnt), .pin_lvl(pin_lvl), .cap_evt(cap_evt), .cap_val(cap_val)
    );

    // Control byte and compare registers, byte-wide writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= '0;
            rise_sel <= 1'b0;
            oc0      <= '1;
            oc1      <= '1;
        end else if (wr) begin
            case (ofs)
                OFS_CTRL: begin
                    en       <= wdata[7:4];
                    rise_sel <= wdata[1];
                end
                OFS_OC0H: oc0[CNT_W-1:BYTE_W] <= wdata;
                OFS_OC0L: oc0[BYTE_W-1:0]     <= wdata;
                OFS_OC1H: oc1[CNT_W-1:BYTE_W] <= wdata;
                OFS_OC1L: oc1[BYTE_W-1:0]     <= wdata;
                default: ;
            endcase
        end
    end

    // Per-flag event sources and clear accesses
    assign set_evt[FL_CAP]  = cap_evt;
    assign set_evt[FL_OC0]  = (cnt == oc0);
    assign set_evt[FL_OC1]  = (cnt == oc1);
    assign set_evt[FL_WRAP] = wrap;
    assign clr_acc[FL_CAP]  = acc && (ofs == OFS_CAPL);
    assign clr_acc[FL_OC0]  = acc && (ofs == OFS_OC0L);
    assign clr_acc[FL_OC1]  = acc && (ofs == OFS_OC1L);
    assign clr_acc[FL_WRAP] = rd  && (ofs == OFS_CNTL);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        evtimer_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set_evt(set_evt[i]),
            .stat_rd(stat_rd), .clr_acc(clr_acc[i]), .flag(flags[i])
        );
    end

    // Registered shared request
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flags & en);
    end

    // Read data multiplexer
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (ofs)
                OFS_CTRL: rdata = {en, 2'b00, rise_sel, 1'b0};
                OFS_STAT: rdata = {flags, pin_lvl, 3'b000};
                OFS_CAPH: rdata = cap_val[CNT_W-1:BYTE_W];
                OFS_CAPL: rdata = cap_val[BYTE_W-1:0];
                OFS_OC0H: rdata = oc0[CNT_W-1:BYTE_W];
                OFS_OC0L: rdata = oc0[BYTE_W-1:0];
                OFS_OC1H: rdata = oc1[CNT_W-1:BYTE_W];
                OFS_OC1L: rdata = oc1[BYTE_W-1:0];
                OFS_CNTH: rdata = cnt[CNT_W-1:BYTE_W];
                OFS_CNTL: rdata = lo_view;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/evtimer_chk.sv
// Property checker for the event timer, bound to evtimer_top.
// Observes counter, flags, clear accesses and the request output.
module evtimer_chk import evtimer_pkg::*; (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [NFLAG-1:0] flags,
    input logic [NFLAG-1:0] en,
    input logic [NFLAG-1:0] set_evt,
    input logic [NFLAG-1:0] clr_acc,
    input logic             stat_rd,
    input logic [7:0]       rdata,
    input logic             irq
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cnt) |=> cnt == $past(cnt) + 1'b1);

    // R4
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt) |=> (cnt == '0) && flags[FL_WRAP]);

    // R1
    stat_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> rdata[2:0] == 3'b000);

    // R9
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |=> !irq);

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(flags & en)));

    for (genvar i = 0; i < NFLAG; i++) begin : g_fl
        // R6
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[i]) |-> $past(clr_acc[i]));
        // R8
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> flags[i]);
    end
endmodule

bind evtimer_top evtimer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .flags(flags), .en(en),
    .set_evt(set_evt), .clr_acc(clr_acc), .stat_rd(stat_rd),
    .rdata(rdata), .irq(irq)
);

// File: tb/evtimer_top_tb.sv
module evtimer_top_tb;
    localparam int P = 10;
    localparam logic [7:0] A_CTRL = 8'h10, A_STAT = 8'h11, A_CAPH = 8'h12,
        A_CAPL = 8'h13, A_OC0H = 8'h14, A_OC0L = 8'h15, A_OC1H = 8'h16,
        A_OC1L = 8'h17, A_CNTH = 8'h18, A_CNTL = 8'h19;

    logic       clk = 0, rst_n = 0, rd_en = 0, wr_en = 0, cap_pin = 0;
    logic [7:0] addr = 0, wdata = 0, rdata;
    logic       irq;
    int         tbcyc = 0, nchk = 0, nfail = 0;

    evtimer_top u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .cap_pin(cap_pin), .irq(irq));

    always #(P/2) clk = ~clk;
    always @(posedge clk) tbcyc <= tbcyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d, output int t);
        @(negedge clk);
        addr = a; rd_en = 1; wr_en = 0;
        #1 d = rdata; t = tbcyc;
        @(posedge clk); #1 rd_en = 0;
    endtask

    task automatic bus_rd_pin(input logic [7:0] a, input logic p, output logic [7:0] d);
        @(negedge clk);
        cap_pin = p; addr = a; rd_en = 1; wr_en = 0;
        #1 d = rdata;
        @(posedge clk); #1 rd_en = 0;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1; rd_en = 0;
        @(posedge clk); #1 wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Coherent counter read: value of the count in the high-byte cycle
    task automatic read_cnt(output logic [15:0] v, output int t0);
        logic [7:0] h, l; int t1;
        bus_rd(A_CNTH, h, t0);
        bus_rd(A_CNTL, l, t1);
        v = {h, l};
    endtask

    task automatic t_reset();
        logic [7:0] d; int t;
        bus_rd(A_CTRL, d, t);  check(d == 8'h00, "R1 ctrl reset", d, 0);
        bus_rd(A_STAT, d, t);  check(d == 8'h00, "R1 status reset", d, 0);
        check(irq == 1'b0, "R1 irq reset", irq, 0);
    endtask

    task automatic t_counter();
        logic [15:0] v0, v1; int t0, t1;
        read_cnt(v0, t0);
        read_cnt(v1, t1);
        check(v1 == v0 + 16'd2, "R2 coherent count step", v1, v0 + 16'd2);
    endtask

    task automatic t_compare(input logic [7:0] ah, input logic [7:0] al,
                             input int bitn, input int ofs, input string tag);
        logic [15:0] v, tgt; logic [7:0] d; int t0, t, seen;
        read_cnt(v, t0);
        tgt = v + 16'(ofs);
        bus_wr(al, tgt[7:0]);
        bus_wr(ah, tgt[15:8]);
        seen = -1;
        for (int k = 0; k < 100; k++) begin
            bus_rd(A_STAT, d, t);
            if (d[bitn]) begin seen = t - t0; break; end
        end
        check(seen == ofs + 1, {tag, " R3 compare flag timing"}, seen, ofs + 1);
        // R9: flag set with enables off keeps irq low
        idle(2);
        check(irq == 1'b0, "R9 irq masked by enable", irq, 0);
        // R7: high byte access does not clear
        bus_rd(ah, d, t);
        bus_rd(A_STAT, d, t);
        check(d[bitn] == 1'b1, {tag, " R7 high byte no clear"}, d, 1);
        // R6: armed low access clears (write for channel 1, read for 0)
        if (bitn == 5) bus_wr(al, tgt[7:0]); else bus_rd(al, d, t);
        bus_rd(A_STAT, d, t);
        check(d[bitn] == 1'b0, {tag, " R6 two-step clear"}, d, 0);
        // R7: set again without arming, low access must not clear
        read_cnt(v, t0);
        tgt = v + 16'd10;
        bus_wr(al, tgt[7:0]);
        bus_wr(ah, tgt[15:8]);
        idle(15);
        bus_rd(al, d, t);
        bus_rd(A_STAT, d, t);
        check(d[bitn] == 1'b1, {tag, " R7 unarmed access no clear"}, d, 1);
        bus_rd(al, d, t);
        bus_rd(A_STAT, d, t);
        check(d[bitn] == 1'b0, {tag, " R6 clear after arm"}, d, 0);
    endtask

    task automatic t_irq();
        logic [15:0] v, tgt; logic [7:0] d; int t0, t, k;
        bus_wr(A_CTRL, 8'h40);
        bus_rd(A_CTRL, d, t);
        check(d == 8'h40, "R9 ctrl readback", d, 8'h40);
        read_cnt(v, t0);
        tgt = v + 16'd12;
        bus_wr(A_OC0L, tgt[7:0]);
        bus_wr(A_OC0H, tgt[15:8]);
        for (k = 0; k < 50 && !irq; k++) @(negedge clk);
        check(irq == 1'b1, "R9 irq asserts", irq, 1);
        bus_rd(A_STAT, d, t);
        bus_rd(A_OC0L, d, t);
        @(negedge clk); #1;
        check(irq == 1'b1, "R9 irq one cycle after clear", irq, 1);
        @(negedge clk); #1;
        check(irq == 1'b0, "R9 irq drops next cycle", irq, 0);
        bus_wr(A_CTRL, 8'h00);
    endtask

    task automatic t_capture();
        logic [15:0] v, cv; logic [7:0] d, h; int t0, t;
        // falling selected: rising edge ignored
        @(negedge clk); cap_pin = 1;
        idle(4);
        bus_rd(A_STAT, d, t);
        check(d[3] == 1'b1, "R10 pin level bit", d, 1);
        check(d[7] == 1'b0, "R5 wrong edge ignored", d, 0);
        read_cnt(v, t0);
        @(negedge clk); cap_pin = 0;
        idle(1);
        bus_rd(A_STAT, d, t);
        check(d[7] == 1'b1 && d[3] == 1'b0, "R5 falling edge sets flag", d, 8'h80);
        bus_rd(A_CAPH, h, t);
        bus_rd(A_CAPL, d, t);
        cv = {h, d};
        check(cv == v + 16'd3, "R5 captured count", cv, v + 16'd3);
        bus_rd(A_STAT, d, t);
        check(d[7] == 1'b0, "R6 capture flag cleared", d, 0);
        // R7: status read while clear does not arm
        bus_wr(A_CTRL, 8'h02);
        @(negedge clk); cap_pin = 1;
        idle(4);
        bus_rd(A_CAPL, d, t);
        bus_rd(A_STAT, d, t);
        check(d[7] == 1'b1, "R7 flag set after clear-time read", d, 1);
        // R8: edge and armed clear in the same cycle
        @(negedge clk); cap_pin = 0;
        idle(4);
        bus_rd_pin(A_STAT, 1'b1, d);
        bus_rd(A_CAPL, d, t);
        bus_rd(A_STAT, d, t);
        check(d[7] == 1'b1, "R8 set wins over clear", d, 1);
        bus_rd(A_CAPL, d, t);
        bus_rd(A_STAT, d, t);
        check(d[7] == 1'b0, "R6 capture cleared after rearm", d, 0);
        bus_wr(A_CTRL, 8'h00);
    endtask

    task automatic t_wrap();
        logic [15:0] v; logic [7:0] d; int t0, t, seen, exp;
        read_cnt(v, t0);
        exp = 65536 - int'(v);
        seen = -1;
        for (int k = 0; k < 70000; k++) begin
            bus_rd(A_STAT, d, t);
            if (d[4]) begin seen = t - t0; break; end
        end
        check(seen == exp, "R4 wrap flag timing", seen, exp);
        bus_rd(A_CNTH, d, t);
        bus_rd(A_STAT, d, t);
        check(d[4] == 1'b1, "R7 wrap not cleared by high byte", d, 1);
        bus_rd(A_CNTL, d, t);
        bus_rd(A_STAT, d, t);
        check(d[4] == 1'b0, "R6 wrap cleared by low count read", d, 0);
    endtask

    initial begin
        #(P * 200000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_counter();
        t_compare(A_OC0H, A_OC0L, 6, 40, "ch0");
        t_compare(A_OC1H, A_OC1L, 5, 25, "ch1");
        t_irq();
        t_capture();
        t_wrap();
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule